// File: doc/BRIEF.md
# Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division for a processor datapath and places every result in a dedicated pair of result registers, HI and LO, rather than in a general register. A multiply produces the full 64-bit product: the upper half goes to HI and the lower half to LO. A divide places the quotient in LO and the remainder in HI. Both multiply and divide come in a signed (two's complement) and an unsigned form. No operation raises an arithmetic exception. Division by zero completes normally and leaves a fixed, defined result.

The unit is iterative. A one-cycle start request with an opcode and two operands is accepted only while the unit is idle. The unit then holds busy high while it runs one shift step per cycle. It pulses done in the cycle in which HI and LO take their new values. The register file reads HI and LO through two output ports at any time. Reading never changes either register.

Top module: `muldiv_hilo`

## Requirements
- R1: Opcode 2'b00 (signed multiply) treats both operands as two's complement and writes the 64-bit product, upper 32 bits to HI and lower 32 bits to LO.
- R2: Opcode 2'b01 (unsigned multiply) treats both operands as unsigned and writes the 64-bit product, upper 32 bits to HI and lower 32 bits to LO.
- R3: Opcode 2'b10 (signed divide) writes to LO the quotient truncated toward zero and to HI the remainder, which carries the sign of the dividend; dividing the most negative value by -1 gives quotient 32'h8000_0000 and remainder 0.
- R4: Opcode 2'b11 (unsigned divide) writes the unsigned quotient to LO and the unsigned remainder to HI.
- R5: A divide whose divisor is zero, signed or unsigned, completes with the normal timing and writes LO = 32'hFFFF_FFFF and HI = the dividend.
- R6: A start request while idle is accepted at that clock edge. Busy is high from the next cycle for exactly 33 cycles. Done is then high for exactly one cycle, with busy low in that cycle.
- R7: HI and LO change only at the edge that raises done, and hold their values at all other times; a start may be accepted in the done cycle itself.
- R8: A start request that arrives while busy is high is ignored: it changes neither the timing nor the result of the operation in progress.
- R9: After reset, busy and done are low and HI and LO are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 2 | Operation code (see R1 to R4) |
| opa_i | input | 32 | First operand: multiplicand or dividend |
| opb_i | input | 32 | Second operand: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when HI and LO are written |
| hi_o | output | 32 | Copy of HI |
| lo_o | output | 32 | Copy of LO |

## Verification
Two functions can fall in the same cycle. The first case is completion of one operation together with acceptance of the next. The bench drives each new start in the very cycle where done is seen. It then checks that the new operation starts busy on the next cycle and that HI and LO still show the previous results until the new done. The second case is a new start request during a running operation. The bench injects such requests with random opcodes and operands at random points while busy is high. It judges them by unchanged latency and by an unchanged result for the operation that was running.

// File: rtl/muldiv_pkg.sv
// Package: shared opcode type for the multiply-divide unit.
// Assumes a 2-bit opcode; bit 1 selects divide, bit 0 selects unsigned.
package muldiv_pkg;
    typedef enum logic [1:0] {
        MD_SMUL = 2'b00,
        MD_UMUL = 2'b01,
        MD_SDIV = 2'b10,
        MD_UDIV = 2'b11
    } md_op_e;
endpackage

// File: rtl/mdu_operand_prep.sv
// Operand preparation: turns raw operands into magnitudes and records
// the signs that the result must take. Purely combinational.
// Assumes W >= 2. Magnitude of the most negative value is 2^(W-1) unsigned.
module mdu_operand_prep
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  md_op_e         op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           div_o,
    output logic [W-1:0]   mag_a_o,
    output logic [W-1:0]   mag_b_o,
    output logic           neg_main_o,
    output logic           neg_rem_o,
    output logic           b_zero_o
);
    logic is_signed;
    logic a_neg;
    logic b_neg;

    // Decode the opcode and derive sign and magnitude information.
    always_comb begin
        is_signed  = (op_i == MD_SMUL) || (op_i == MD_SDIV);
        div_o      = (op_i == MD_SDIV) || (op_i == MD_UDIV);
        a_neg      = is_signed && a_i[W-1];
        b_neg      = is_signed && b_i[W-1];
        mag_a_o    = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b_o    = b_neg ? (~b_i + 1'b1) : b_i;
        neg_main_o = a_neg ^ b_neg;
        neg_rem_o  = a_neg;
        b_zero_o   = (b_i == '0);
    end
endmodule

// File: rtl/mdu_iter_core.sv
// Iterative core: one shift-add multiply step or one restoring divide step
// per cycle on unsigned magnitudes, W steps per operation.
// Assumes load_i and run_i are never high together (top only loads when idle).
module mdu_iter_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           run_i,
    input  logic           div_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic           last_o,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc_hi;
    logic [W-1:0]  acc_lo;
    logic [W-1:0]  dvs;
    logic          mode_div;
    logic [CW-1:0] cnt;

    logic [W:0]    mul_sum;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Next-step arithmetic for both algorithms.
    always_comb begin
        mul_sum = {1'b0, acc_hi[W-1:0]} + (acc_lo[0] ? {1'b0, dvs} : '0);
        shifted = {acc_hi[W-1:0], acc_lo[W-1]};
        trial   = shifted - {1'b0, dvs};
    end

    // Load operands, then step the accumulator and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi   <= '0;
            acc_lo   <= '0;
            dvs      <= '0;
            mode_div <= 1'b0;
            cnt      <= '0;
        end else if (load_i) begin
            acc_hi   <= '0;
            acc_lo   <= opa_i;
            dvs      <= opb_i;
            mode_div <= div_i;
            cnt      <= CW'(W);
        end else if (run_i && cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (mode_div) begin
                if (!trial[W]) begin
                    acc_hi <= trial;
                    acc_lo <= {acc_lo[W-2:0], 1'b1};
                end else begin
                    acc_hi <= shifted;
                    acc_lo <= {acc_lo[W-2:0], 1'b0};
                end
            end else begin
                acc_hi <= {1'b0, mul_sum[W:1]};
                acc_lo <= {mul_sum[0], acc_lo[W-1:1]};
            end
        end
    end

    assign last_o = (cnt == '0);
    assign hi_o   = acc_hi[W-1:0];
    assign lo_o   = acc_lo;

    // R4: the partial remainder stays below a nonzero divisor at every step.
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && mode_div && dvs != '0) |-> (acc_hi < {1'b0, dvs}));
endmodule

// File: rtl/mdu_result_fix.sv
// Result correction: applies the recorded signs to the unsigned core result
// and forces the defined divide-by-zero quotient. Purely combinational.
// Assumes core hi/lo hold product halves (multiply) or remainder/quotient.
module mdu_result_fix #(
    parameter int W = 32
) (
    input  logic           div_i,
    input  logic           neg_main_i,
    input  logic           neg_rem_i,
    input  logic           b_zero_i,
    input  logic [W-1:0]   core_hi_i,
    input  logic [W-1:0]   core_lo_i,
    output logic [W-1:0]   res_hi_o,
    output logic [W-1:0]   res_lo_o
);
    logic [2*W-1:0] prod;

    // Select the signed or unsigned form of product, quotient and remainder.
    always_comb begin
        prod = {core_hi_i, core_lo_i};
        if (neg_main_i) prod = ~prod + 1'b1;
        if (div_i) begin
            res_hi_o = neg_rem_i ? (~core_hi_i + 1'b1) : core_hi_i;
            if (b_zero_i)        res_lo_o = '1;
            else if (neg_main_i) res_lo_o = ~core_lo_i + 1'b1;
            else                 res_lo_o = core_lo_i;
        end else begin
            res_hi_o = prod[2*W-1:W];
            res_lo_o = prod[W-1:0];
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
// Top: multiply-divide unit with a HI/LO result register pair.
// Accepts a start only when idle, runs W core steps, then writes HI and LO
// together and pulses done. Assumes opcode encoding from muldiv_pkg.
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [1:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [W-1:0]   hi_o,
    output logic [W-1:0]   lo_o
);
    logic           busy_q;
    logic           done_q;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;
    logic           div_q;
    logic           negm_q;
    logic           negr_q;
    logic           bz_q;

    logic           accept;
    logic           finish;
    logic           p_div;
    logic [W-1:0]   p_mag_a;
    logic [W-1:0]   p_mag_b;
    logic           p_negm;
    logic           p_negr;
    logic           p_bz;
    logic           core_last;
    logic [W-1:0]   core_hi;
    logic [W-1:0]   core_lo;
    logic [W-1:0]   fix_hi;
    logic [W-1:0]   fix_lo;

    mdu_operand_prep #(.W(W)) prep_i (
        .op_i       (md_op_e'(op_i)),
        .a_i        (opa_i),
        .b_i        (opb_i),
        .div_o      (p_div),
        .mag_a_o    (p_mag_a),
        .mag_b_o    (p_mag_b),
        .neg_main_o (p_negm),
        .neg_rem_o  (p_negr),
        .b_zero_o   (p_bz)
    );

    mdu_iter_core #(.W(W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .run_i  (busy_q),
        .div_i  (p_div),
        .opa_i  (p_mag_a),
        .opb_i  (p_mag_b),
        .last_o (core_last),
        .hi_o   (core_hi),
        .lo_o   (core_lo)
    );

    mdu_result_fix #(.W(W)) fix_i (
        .div_i      (div_q),
        .neg_main_i (negm_q),
        .neg_rem_i  (negr_q),
        .b_zero_i   (bz_q),
        .core_hi_i  (core_hi),
        .core_lo_i  (core_lo),
        .res_hi_o   (fix_hi),
        .res_lo_o   (fix_lo)
    );

    assign accept = start_i && !busy_q;
    assign finish = busy_q && core_last;

    // Control and result registers: accept, complete, commit HI/LO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
            div_q  <= 1'b0;
            negm_q <= 1'b0;
            negr_q <= 1'b0;
            bz_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q <= 1'b1;
                div_q  <= p_div;
                negm_q <= p_negm;
                negr_q <= p_negr;
                bz_q   <= p_bz;
            end else if (finish) begin
                busy_q <= 1'b0;
                hi_q   <= fix_hi;
                lo_q   <= fix_lo;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;

    // R6: done lasts one cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: done comes with busy low, right after a busy cycle.
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));
    // R7: HI changes only with done.
    a_r7_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hi_o) |-> done_o);
    // R7: LO changes only with done.
    a_r7_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lo_o) |-> done_o);
    // R8: busy only rises from a start request seen while idle.
    a_r8_busy_from_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(start_i) && !$past(busy_o)));
endmodule

// File: tb/muldiv_hilo_tb_top.sv
`timescale 1ns/1ps
module muldiv_hilo_tb_top;
    localparam int W   = 32;
    localparam int LAT = W + 2;   // negedges from start drive to done

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    op_i = 2'b00;
    logic [W-1:0]  opa_i = '0;
    logic [W-1:0]  opb_i = '0;
    logic          busy_o;
    logic          done_o;
    logic [W-1:0]  hi_o;
    logic [W-1:0]  lo_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] prev_hi = '0;
    logic [W-1:0] prev_lo = '0;

    always #2.5 clk = ~clk;

    muldiv_hilo #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
        .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {HI, LO} from the requirements.
    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint q;
        longint r;
        logic [63:0] ua = {32'b0, a};
        logic [63:0] ub = {32'b0, b};
        case (op)
            2'b00: return 64'(sa * sb);
            2'b01: return ua * ub;
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                if (op == 2'b10) begin
                    q = sa / sb;
                    r = sa % sb;
                    return {r[31:0], q[31:0]};
                end
                return {32'(ua % ub), 32'(ua / ub)};
            end
        endcase
    endfunction

    function automatic string tag(input logic [1:0] op, input logic [31:0] b);
        if (op[1] && b == 0) return "R5 div-by-zero";
        case (op)
            2'b00: return "R1 signed mul";
            2'b01: return "R2 unsigned mul";
            2'b10: return "R3 signed div";
            default: return "R4 unsigned div";
        endcase
    endfunction

    // Issue one operation at a negedge; return at the negedge where done is seen.
    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit inject);
        logic [63:0] exp = model(op, a, b);
        int lat = 1;
        int inj_at = 3 + int'($urandom % 25);
        bit held = 1;
        start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
        @(negedge clk);
        start_i = 1'b0;
        opa_i = $urandom; opb_i = $urandom; op_i = 2'($urandom);
        check(busy_o && !done_o, "R6 busy after accept", {62'b0, busy_o, done_o}, 64'd2);
        while (!done_o && lat < 100) begin
            if (hi_o != prev_hi || lo_o != prev_lo) held = 0;
            if (inject && lat == inj_at) begin
                start_i = 1'b1; op_i = 2'($urandom); opa_i = $urandom; opb_i = $urandom;
            end
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        check(held, "R7 HI/LO hold while busy", {hi_o, lo_o}, {prev_hi, prev_lo});
        check(lat == LAT && !busy_o, inject ? "R8 latency with ignored start" : "R6 latency",
              64'(lat), 64'(LAT));
        check({hi_o, lo_o} == exp, inject ? {"R8 result intact / ", tag(op, b)} : tag(op, b),
              {hi_o, lo_o}, exp);
        prev_hi = exp[63:32];
        prev_lo = exp[31:0];
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!busy_o && !done_o && hi_o == 0 && lo_o == 0, "R9 reset state",
              {busy_o, done_o, hi_o[30:0], lo_o}, 64'd0);

        // Directed corners, back-to-back (each start in the previous done cycle).
        run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0);
        run_op(2'b00, 32'hFFFF_FFFD, 32'd5, 0);
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0);
        run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0);
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0);
        run_op(2'b11, 32'hFFFF_FFFF, 32'd3, 0);
        run_op(2'b10, 32'hFFFF_FF00, 32'd0, 0);
        run_op(2'b11, 32'h1234_5678, 32'd0, 1);
        run_op(2'b11, 32'd5, 32'd9, 1);

        // One-cycle done pulse (R6) and idle hold of HI/LO (R7).
        @(negedge clk);
        check(!done_o && !busy_o, "R6 done single cycle", {62'b0, busy_o, done_o}, 64'd0);
        repeat (3) @(negedge clk);
        check(hi_o == prev_hi && lo_o == prev_lo, "R7 HI/LO hold while idle",
              {hi_o, lo_o}, {prev_hi, prev_lo});

        // Constrained random mix.
        for (int i = 0; i < 80; i++) begin
            logic [1:0]  op = 2'($urandom);
            logic [31:0] a = $urandom;
            logic [31:0] b = $urandom;
            if ($urandom % 8 == 0) b = 0;
            else if ($urandom % 4 == 0) b = b >> ($urandom % 31);
            if ($urandom % 6 == 0) a = {a[31], 31'(a[30:0] >> ($urandom % 31))};
            run_op(op, a, b, ($urandom % 4) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule